// File: doc/BRIEF.md
# Register-Mapped Display-Data Responder

This block stands in for the display-data target that sits behind a small four-register serial bus controller. It never drives a bus. Software programs it through a strobe-based register port. One register picks a pin pair, which maps to a display port. One register takes a command. One register reports status. One register returns data. A command decodes into a transfer phase and a set of status flags. Each read of the data register then pulls up to four bytes from a 128-byte display-identification table that belongs to the selected port.

The table contents come from a fixed formula, so the block needs no memory. Two per-port inputs say whether a monitor is attached and whether that monitor uses a packet link rather than the serial bus. Only a monitor that is present and not on the packet link can serve data. Register reads are registered: the value appears on `reg_rdata` one clock after the read strobe.

Top module: `edid_i2c_resp`

## Requirements
- R1: After reset the status word is 0x001, which means ready with the phase idle. A data-register read returns 0. Status layout: bit0 ready, bit1 wait-seen, bit2 active, bit3 no-acknowledge error, bit4 in-use, bits 9:8 phase (0 idle, 1 data, 2 wait).
- R2: The command word holds these fields: a byte count in bits 24:16, a target address in bits 7:1, a read-direction flag in bit 0, an index byte in bits 15:8 and a cycle code in bits 27:25. Codes 1, 3, 5 and 7 enter the data phase and set active. Code 0 changes nothing. Codes 2 and 6 leave the phase and the active flag unchanged.
- R3: Target address 0x50 selects the table. Any other address leaves the target unselected, so every byte read returns 0x00.
- R4: When bit 26 of a command is 1, the read pointer loads from the index byte.
- R5: A data read in read direction returns min(4, count − pointer) bytes, packed little-endian from bit 7:0 upward. The table byte for port p at index i is (7·i + 64·p + 29) mod 256.
- R6: Lanes that a data read does not fill keep their earlier value. When count − pointer ≤ 0, the read returns the held word unchanged.
- R7: A read that consumes the last bytes sets the phase to idle for codes 5 and 7 and to wait for codes 1 and 3. It then clears the pointer, the target selection and data availability, so later reads return zeros until a new pin select.
- R8: Code 4 returns the phase to idle and clears active only when the previously stored code is nonzero. Otherwise it changes nothing.
- R9: A status read returns the current word and then sets in-use. Writing 1 to bit 4 of the status register clears in-use. Every other status bit ignores writes.
- R10: Pin codes 1 to 4 map to ports 0 to 3. A mapped code clears active, sets ready and wait-seen, and sets the phase to idle. It clears the error flag when the port has a monitor that is not on the packet link, and sets the error flag otherwise. Codes 0 and 5 to 7 only reset the transfer context.
- R11: Command bit 31 works in two steps. Writing it as 1 sets ready. Then, while the stored bit 31 is 1, a write with bit 31 at 0 clears only that stored bit, sets status to ready plus the error flag if no data is available, and sets the phase to idle. Stored bit 30 always reads 0.
- R12: Writes to the data register have no effect. A byte whose index is past 127 reads as 0x00 and does not move the pointer.
- R13: A data read while the stored read-direction flag is 0 returns the held word and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; ignored when reg_wr is also high |
| reg_addr | input | 2 | Register select: 0 pin, 1 command, 2 status, 3 data |
| reg_wdata | input | 32 | Write data |
| mon_present | input | NUM_PORTS | A monitor is attached, one bit per port |
| mon_is_dp | input | NUM_PORTS | The attached monitor uses the packet link, one bit per port |
| reg_rdata | output | 32 | Read data, valid one clock after the read strobe |

## Verification
A wrong pointer shows up on the very next data read as shifted or missing table bytes. A wrong byte count shows up as a wrong number of overwritten lanes, or as a phase that never leaves data. A corrupted phase or active flag appears in bits 9:8 and bit 2 of the next status read. A stale context shows up as nonzero bytes where zeros are due after a transfer closes. Because every read is registered, each of these faults is visible exactly one clock after the read strobe that exposes it.

// File: rtl/edid_resp_pkg.sv
package edid_resp_pkg;

    localparam int DATA_W = 32;
    localparam logic [6:0] TABLE_TARGET = 7'h50;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic in_use;
        logic err;
        logic active;
        logic wait_ph;
        logic ready;
    } stat_t;

    // Generated identification table byte for a port and an index
    function automatic logic [7:0] table_byte(input logic [7:0] port, input logic [7:0] idx);
        return idx * 8'd7 + {port[1:0], 6'b0} + 8'h1D;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input stat_t s, input phase_e ph);
        return {22'b0, ph, 3'b0, s.in_use, s.err, s.active, s.wait_ph, s.ready};
    endfunction

endpackage

// File: rtl/edid_pin_map.sv
module edid_pin_map #(
    parameter int NUM_PORTS = 4,
    parameter int PW = 2
) (
    input  logic [2:0]    code,
    output logic [PW-1:0] port,
    output logic          hit
);
    always_comb begin
        port = '0;
        hit  = 1'b0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (code == 3'(k + 1)) begin
                port = PW'(k);
                hit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/edid_cmd_decode.sv
module edid_cmd_decode (
    input  logic [31:0] cmd,
    output logic [8:0]  total,
    output logic [6:0]  target,
    output logic [7:0]  index,
    output logic [2:0]  cyc,
    output logic        idx_load,
    output logic        is_stop,
    output logic        is_xfer,
    output logic        clr_int,
    output logic [31:0] stored
);
    assign total    = cmd[24:16];
    assign target   = cmd[7:1];
    assign index    = cmd[15:8];
    assign cyc      = cmd[27:25];
    assign idx_load = cmd[26];
    assign is_stop  = (cmd[27:25] == 3'd4);
    assign is_xfer  = cmd[25];
    assign clr_int  = cmd[31];
    assign stored   = {cmd[31], 1'b0, cmd[29:0]};
endmodule

// File: rtl/edid_byte_packer.sv
module edid_byte_packer #(
    parameter int LANES = 4,
    parameter int TABLE_BYTES = 128,
    parameter int PW = 2
) (
    input  logic [7:0]         ptr,
    input  logic [8:0]         total,
    input  logic [PW-1:0]      port,
    input  logic               fetch_ok,
    output logic [8*LANES-1:0] word,
    output logic [LANES-1:0]   lane_we,
    output logic [7:0]         ptr_next,
    output logic               has_left,
    output logic               last
);
    import edid_resp_pkg::*;

    logic signed [9:0] left;
    logic [LANES-1:0]  lane_ok;

    assign left     = $signed({1'b0, total}) - $signed({2'b0, ptr});
    assign has_left = (left > 10'sd0);
    assign last     = (left <= $signed(10'(LANES)));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [8:0] idx;
        assign idx        = {1'b0, ptr} + 9'(g);
        assign lane_we[g] = (left > $signed(10'(g)));
        assign lane_ok[g] = fetch_ok && lane_we[g] && (idx < 9'(TABLE_BYTES));
        assign word[8*g +: 8] = lane_ok[g] ? table_byte(8'(port), idx[7:0]) : 8'h00;
    end

    always_comb begin
        ptr_next = ptr;
        for (int i = 0; i < LANES; i++) begin
            ptr_next = ptr_next + {7'b0, lane_ok[i]};
        end
    end
endmodule

// File: rtl/edid_i2c_resp.sv
module edid_i2c_resp #(
    parameter int NUM_PORTS = 4,
    parameter int TABLE_BYTES = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic [NUM_PORTS-1:0] mon_present,
    input  logic [NUM_PORTS-1:0] mon_is_dp,
    output logic [31:0]          reg_rdata
);
    import edid_resp_pkg::*;

    localparam int PW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [7:0]    ptr;
        logic          sel;
        logic          avail;
        logic [PW-1:0] port;
    } ctx_t;

    typedef struct packed {
        logic [31:0] pin;
        logic [31:0] cmd;
        logic [31:0] data;
        logic [31:0] rdata;
        stat_t       st;
        phase_e      phase;
        logic [8:0]  count;
        logic [2:0]  cyc;
        ctx_t        ctx;
    } state_t;

    state_t s_d, s_q;

    // Pin decode
    logic [PW-1:0] pin_port;
    logic          pin_hit;

    edid_pin_map #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_pin (
        .code (reg_wdata[2:0]),
        .port (pin_port),
        .hit  (pin_hit)
    );

    // Command field decode of the incoming write
    logic [8:0]  w_total;
    logic [6:0]  w_target;
    logic [7:0]  w_index;
    logic [2:0]  w_cyc;
    logic        w_idx_load, w_is_stop, w_is_xfer, w_clr_int;
    logic [31:0] w_stored;

    edid_cmd_decode u_dec (
        .cmd      (reg_wdata),
        .total    (w_total),
        .target   (w_target),
        .index    (w_index),
        .cyc      (w_cyc),
        .idx_load (w_idx_load),
        .is_stop  (w_is_stop),
        .is_xfer  (w_is_xfer),
        .clr_int  (w_clr_int),
        .stored   (w_stored)
    );

    // Table fetch for the data register
    logic [DATA_W-1:0] pk_word;
    logic [LANES-1:0]  pk_we;
    logic [7:0]        pk_ptr;
    logic              pk_has_left, pk_last;

    edid_byte_packer #(.LANES(LANES), .TABLE_BYTES(TABLE_BYTES), .PW(PW)) u_pack (
        .ptr      (s_q.ctx.ptr),
        .total    (s_q.count),
        .port     (s_q.ctx.port),
        .fetch_ok (s_q.ctx.sel && s_q.ctx.avail),
        .word     (pk_word),
        .lane_we  (pk_we),
        .ptr_next (pk_ptr),
        .has_left (pk_has_left),
        .last     (pk_last)
    );

    logic rd_fire;
    assign rd_fire = reg_rd && !reg_wr;

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            unique case (reg_addr)
                2'd0: begin
                    s_d.pin   = reg_wdata;
                    s_d.ctx   = '0;
                    s_d.phase = PH_IDLE;
                    s_d.count = '0;
                    s_d.cyc   = '0;
                    if (pin_hit) begin
                        s_d.st.ready   = 1'b1;
                        s_d.st.wait_ph = 1'b1;
                        s_d.st.active  = 1'b0;
                        if (mon_present[pin_port] && !mon_is_dp[pin_port]) begin
                            s_d.ctx.port  = pin_port;
                            s_d.ctx.avail = 1'b1;
                            s_d.st.err    = 1'b0;
                        end else begin
                            s_d.st.err = 1'b1;
                        end
                    end
                end
                2'd1: begin
                    if (s_q.cmd[31]) begin
                        if (!w_clr_int) begin
                            s_d.cmd[31] = 1'b0;
                            s_d.st       = '0;
                            s_d.st.ready = 1'b1;
                            s_d.st.err   = !s_q.ctx.avail;
                            s_d.phase    = PH_IDLE;
                        end
                    end else begin
                        if (w_clr_int) s_d.st.ready = 1'b1;
                        s_d.count = w_total;
                        if (w_target == TABLE_TARGET) s_d.ctx.sel = 1'b1;
                        if (w_idx_load) s_d.ctx.ptr = w_index;
                        s_d.cyc = w_cyc;
                        if (w_is_stop) begin
                            if (s_q.cmd[27:25] != 3'd0) begin
                                s_d.ctx       = '0;
                                s_d.count     = '0;
                                s_d.cyc       = '0;
                                s_d.phase     = PH_IDLE;
                                s_d.st.active = 1'b0;
                            end
                        end else if (w_is_xfer) begin
                            s_d.phase     = PH_DATA;
                            s_d.st.active = 1'b1;
                        end
                        s_d.cmd = w_stored;
                    end
                end
                2'd2: begin
                    if (reg_wdata[4]) s_d.st.in_use = 1'b0;
                end
                2'd3: begin
                    // data register is read-only from the bus side
                end
            endcase
        end else if (rd_fire) begin
            unique case (reg_addr)
                2'd0: s_d.rdata = s_q.pin;
                2'd1: s_d.rdata = s_q.cmd;
                2'd2: begin
                    s_d.rdata     = pack_status(s_q.st, s_q.phase);
                    s_d.st.in_use = 1'b1;
                end
                2'd3: begin
                    if (s_q.cmd[0] && pk_has_left) begin
                        for (int i = 0; i < LANES; i++) begin
                            if (pk_we[i]) s_d.data[8*i +: 8] = pk_word[8*i +: 8];
                        end
                        s_d.ctx.ptr = pk_ptr;
                        if (pk_last) begin
                            s_d.phase = s_q.cyc[2] ? PH_IDLE : PH_WAIT;
                            s_d.ctx.ptr   = '0;
                            s_d.ctx.sel   = 1'b0;
                            s_d.ctx.avail = 1'b0;
                        end
                    end
                    s_d.rdata = s_d.data;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st.ready <= 1'b1;
            s_q.phase    <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;

    // Observation points for the bound checker
    logic       chk_swrdy;
    logic       chk_in_use;
    logic       chk_active;
    logic [1:0] chk_phase;
    logic [7:0] chk_ptr;
    assign chk_swrdy  = s_q.cmd[30];
    assign chk_in_use = s_q.st.in_use;
    assign chk_active = s_q.st.active;
    assign chk_phase  = s_q.phase;
    assign chk_ptr    = s_q.ctx.ptr;

endmodule

// File: rtl/edid_resp_chk.sv
module edid_resp_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       wd_inuse,
    input logic [2:0] wd_pin,
    input logic       swrdy,
    input logic       in_use,
    input logic       active,
    input logic [1:0] phase,
    input logic [7:0] ptr
);
    // R11
    swrdy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> !swrdy);

    // R9
    inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 2'd2) |=> in_use);

    // R9
    inuse_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && wd_inuse) |=> !in_use);

    // R2
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    // R10
    pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && wd_pin != 3'd0 && 32'(wd_pin) <= NUM_PORTS)
        |=> (phase == 2'd0 && !active));

    // R12
    data_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> ($stable(ptr) && $stable(phase)));

    // R5
    ptr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 2'd3) |=> (ptr >= $past(ptr) || ptr == 8'd0));
endmodule

bind edid_i2c_resp edid_resp_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .wd_inuse (reg_wdata[4]),
    .wd_pin   (reg_wdata[2:0]),
    .swrdy    (chk_swrdy),
    .in_use   (chk_in_use),
    .active   (chk_active),
    .phase    (chk_phase),
    .ptr      (chk_ptr)
);

// File: tb/sim_edid_i2c_resp.sv
module sim_edid_i2c_resp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [3:0]  mon_present = 4'b0111;
    logic [3:0]  mon_is_dp = 4'b0010;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edid_i2c_resp u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .mon_present (mon_present),
        .mon_is_dp   (mon_is_dp),
        .reg_rdata   (reg_rdata)
    );

    function automatic logic [7:0] tb_byte(input int p, input int i);
        return 8'((7 * i + 64 * p + 29) % 256);
    endfunction

    function automatic logic [31:0] cmd(input int cyc, input int cnt, input int idx, input int addr_byte);
        return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) | 32'(addr_byte);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic stat(input string req, input logic [31:0] exp);
        logic [31:0] v;
        wr(2'd2, 32'h10);
        rd(2'd2, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd2, v); check("R1 reset status", v, 32'h001);
        rd(2'd3, v); check("R1 reset data", v, 32'h0);
    endtask

    task automatic t_pin;
        logic [31:0] v;
        wr(2'd0, 32'd1); stat("R10 pin1 present", 32'h003);
        wr(2'd0, 32'd2); stat("R10 pin2 packet link", 32'h00B);
        wr(2'd0, 32'd6); stat("R10 unmapped pin", 32'h00B);
        wr(2'd0, 32'd4); stat("R10 pin4 absent", 32'h00B);
        wr(2'd0, 32'd3); stat("R10 pin3 present", 32'h003);
        rd(2'd0, v); check("R10 pin readback", v, 32'd3);
    endtask

    task automatic t_clrint;
        logic [31:0] v;
        wr(2'd0, 32'd2);
        wr(2'd1, 32'hC000_0000 | cmd(1, 4, 0, 8'hA1));
        stat("R11 set step", 32'h10F);
        rd(2'd1, v); check("R11 bit30 forced", v, 32'h8204_00A1);
        wr(2'd1, 32'h0);
        stat("R11 release step", 32'h009);
        rd(2'd1, v); check("R11 stored after release", v, 32'h0204_00A1);
    endtask

    task automatic t_read;
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, cmd(5, 6, 0, 8'hA1));
        stat("R2 transfer active", 32'h107);
        rd(2'd3, v);
        check("R5 first word", v, {tb_byte(0,3), tb_byte(0,2), tb_byte(0,1), tb_byte(0,0)});
        rd(2'd3, v);
        check("R6 partial word", v, {tb_byte(0,3), tb_byte(0,2), tb_byte(0,5), tb_byte(0,4)});
        stat("R7 stop cycle idle", 32'h007);
    endtask

    task automatic t_noread;
        logic [31:0] v;
        logic [31:0] held;
        held = {tb_byte(0,3), tb_byte(0,2), tb_byte(0,5), tb_byte(0,4)};
        wr(2'd1, cmd(1, 0, 0, 8'hA0));
        rd(2'd3, v); check("R13 write direction", v, held);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, v); check("R12 data write ignored", v, held);
        wr(2'd1, cmd(1, 0, 0, 8'hA1));
        rd(2'd3, v); check("R6 nothing left", v, held);
        wr(2'd1, cmd(1, 4, 0, 8'hA1));
        rd(2'd3, v); check("R7 context cleared", v, 32'h0);
    endtask

    task automatic t_index;
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, cmd(3, 130, 125, 8'hA1));
        rd(2'd3, v);
        check("R4 index load", v, {8'h00, tb_byte(0,127), tb_byte(0,126), tb_byte(0,125)});
        rd(2'd3, v);
        check("R12 past end", v, {8'h00, tb_byte(0,127), 16'h0000});
        stat("R7 no-stop wait", 32'h207);
    endtask

    task automatic t_other;
        logic [31:0] v;
        wr(2'd0, 32'd1);
        wr(2'd1, cmd(1, 4, 0, 8'h61));
        rd(2'd3, v); check("R3 foreign target", v, 32'h0);
        wr(2'd0, 32'd3);
        wr(2'd1, cmd(7, 2, 0, 8'hA1));
        rd(2'd3, v);
        check("R5 port2 bytes", v, {16'h0000, tb_byte(2,1), tb_byte(2,0)});
        stat("R7 index stop idle", 32'h007);
    endtask

    task automatic t_stop;
        wr(2'd1, cmd(1, 0, 0, 0));  stat("R2 xfer", 32'h107);
        wr(2'd1, cmd(0, 0, 0, 0));  stat("R2 no-cycle", 32'h107);
        wr(2'd1, cmd(4, 0, 0, 0));  stat("R8 stop after none", 32'h107);
        wr(2'd1, cmd(4, 0, 0, 0));  stat("R8 stop after stop", 32'h003);
        wr(2'd1, cmd(1, 0, 0, 0));  stat("R2 xfer again", 32'h107);
        wr(2'd1, cmd(2, 0, 0, 0));  stat("R2 reserved code", 32'h107);
        wr(2'd1, cmd(4, 0, 0, 0));  stat("R8 stop after reserved", 32'h003);
    endtask

    task automatic t_inuse;
        logic [31:0] v;
        wr(2'd2, 32'h10);
        rd(2'd2, v); check("R9 first read", v, 32'h003);
        rd(2'd2, v); check("R9 in-use set", v, 32'h013);
        wr(2'd2, 32'hFFFF_FFEF);
        rd(2'd2, v); check("R9 read-only bits", v, 32'h013);
        wr(2'd2, 32'h10);
        rd(2'd2, v); check("R9 in-use cleared", v, 32'h003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pin();
        t_clrint();
        t_read();
        t_noread();
        t_index();
        t_other();
        t_stop();
        t_inuse();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule